// File: doc/BRIEF.md
# Counter-Based Digital Phase Meter

This block measures the phase lag between two square waves of the same frequency. Upstream, zero-crossing comparators square up the two signals. One square wave is the reference and the other is the response. Each rising edge of the reference arms a set/reset discriminator, and the next rising edge of the response disarms it. The time the discriminator stays armed is the phase lag.

Both the armed interval and the full reference period are counted in units of a sampling enable. An external frequency-recovery loop drives that enable at N times the signal frequency. Because the enable tracks the signal, the phase resolution does not depend on the signal frequency.

At every reference rising edge, the block latches the two counts and starts a bit-serial divider. The divider scales the pulse count to a binary phase code of PHASE_W bits, where full scale is one period. When the code is ready, the block presents it together with both counts and a one-cycle valid strobe. If the response edge never arrives within a period, the block reports a timeout with a saturated result.

Top module: `pm_phase_meter`

## Requirements
- R1: Both `refIn` and `rspIn` pass through a two-flop synchronizer. Only rising transitions act as edges; falling transitions have no effect on any count.
- R2: `pulseCount` equals the number of clock cycles with `sampleEn` high, counted from the reference rising-edge cycle (inclusive) to the following response rising-edge cycle (exclusive).
- R3: `periodCount` equals the number of cycles with `sampleEn` high between consecutive reference rising edges. It is never smaller than `pulseCount`.
- R4: When there is no timeout and `pulseCount` < `periodCount`, `phaseCode` equals floor(`pulseCount` * 2^PHASE_W / `periodCount`). PHASE_W may be set from 8 to 12.
- R5: If no response rising edge arrives between two reference rising edges, the result shows all of the following: `timeout` = 1, `pulseCount` = `periodCount`, and `phaseCode` all ones. A normal measurement reports `timeout` = 0.
- R6: `valid` is high for exactly one cycle per reported measurement. The first reference rising edge after reset starts the first period and reports nothing.
- R7: A response rising edge in the same cycle as the reference rising edge gives `pulseCount` = 0 and `phaseCode` = 0.
- R8: During and right after reset, `valid`, `timeout`, `phaseCode`, `pulseCount` and `periodCount` are all zero.
- R9: Cycles with `sampleEn` low are not counted. With the enable high once every k cycles, both counts scale down by k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refIn | input | 1 | Squared reference signal, asynchronous |
| rspIn | input | 1 | Squared response signal, asynchronous |
| sampleEn | input | 1 | Counting enable at N times the signal frequency |
| valid | output | 1 | One-cycle strobe marking a new result |
| phaseCode | output | PHASE_W | Phase lag scaled so that 2^PHASE_W is one period |
| pulseCount | output | CNT_W | Enabled cycles during the discriminator pulse |
| periodCount | output | CNT_W | Enabled cycles in the reference period |
| timeout | output | 1 | Response edge missing in the measured period |

## Verification
Three conditions are hard to produce from the ports: a response edge in exactly the same cycle as the reference edge, a response that never rises, and a sparse enable whose alignment could skew the counts.

The bench generates both square waves from a single cycle counter, so the lag is an exact whole number of cycles and a lag of zero makes the two edges coincide. It sweeps every lag over small periods, holds the response low to force a timeout, and picks periods and lags that are multiples of the enable spacing. With that choice, the expected counts do not depend on where the enable falls.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef struct packed {
    logic periodRestart;
    logic periodInc;
    logic pulseRestart;
    logic pulseSeed;
    logic pulseInc;
    logic capture;
    logic timeoutHit;
    logic divStep;
    logic divDone;
  } pmStrobeT;

endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int PHASE_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     refIn,
  input  logic     rspIn,
  input  logic     sampleEn,
  output pmStrobeT strobes
);

  localparam int STEP_W = $clog2(PHASE_W + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PHASE_W);

  logic [2:0] refSync;
  logic [2:0] rspSync;
  logic       refRise;
  logic       rspRise;
  logic       discOn;
  logic       firstSeen;
  logic       busy;
  logic [STEP_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refSync <= '0;
      rspSync <= '0;
    end else begin
      refSync <= {refSync[1:0], refIn};
      rspSync <= {rspSync[1:0], rspIn};
    end
  end

  assign refRise = refSync[1] & ~refSync[2];
  assign rspRise = rspSync[1] & ~rspSync[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      discOn    <= 1'b0;
      firstSeen <= 1'b0;
    end else begin
      if (rspRise)      discOn <= 1'b0;
      else if (refRise) discOn <= 1'b1;
      if (refRise) firstSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
    end else if (strobes.capture) begin
      busy    <= 1'b1;
      stepCnt <= '0;
    end else if (busy) begin
      if (stepCnt == LAST_STEP) busy <= 1'b0;
      else                      stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.periodRestart = refRise;
    strobes.periodInc     = sampleEn;
    strobes.pulseRestart  = refRise;
    strobes.pulseSeed     = refRise & ~rspRise & sampleEn;
    strobes.pulseInc      = discOn & ~rspRise & sampleEn;
    strobes.capture       = refRise & firstSeen & ~busy;
    strobes.timeoutHit    = discOn & ~rspRise;
    strobes.divStep       = busy & (stepCnt != LAST_STEP);
    strobes.divDone       = busy & (stepCnt == LAST_STEP);
  end

  // R2: a response edge always disarms the discriminator
  a_r2_disc_clears: assert property (@(posedge clk) disable iff (!rstN)
    rspRise |=> !discOn);

  // R6: the divider finishes once, then goes idle
  a_r6_done_once: assert property (@(posedge clk) disable iff (!rstN)
    strobes.divDone |=> (!strobes.divDone && !busy));

endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pmStrobeT           strobes,
  output logic               valid,
  output logic [PHASE_W-1:0] phaseCode,
  output logic [CNT_W-1:0]   pulseCount,
  output logic [CNT_W-1:0]   periodCount,
  output logic               timeout
);

  logic [CNT_W-1:0]   periodCnt;
  logic [CNT_W-1:0]   pulseCnt;
  logic [CNT_W-1:0]   capPulse;
  logic [CNT_W-1:0]   heldPulse;
  logic [CNT_W-1:0]   heldPeriod;
  logic               heldTimeout;
  logic               satFlag;
  logic [CNT_W-1:0]   rem;
  logic [CNT_W:0]     remShift;
  logic               fits;
  logic [PHASE_W-1:0] quot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
      pulseCnt  <= '0;
    end else begin
      if (strobes.periodRestart)
        periodCnt <= CNT_W'(strobes.periodInc);
      else if (strobes.periodInc && periodCnt != '1)
        periodCnt <= periodCnt + 1'b1;
      if (strobes.pulseRestart)
        pulseCnt <= CNT_W'(strobes.pulseSeed);
      else if (strobes.pulseInc && pulseCnt != '1)
        pulseCnt <= pulseCnt + 1'b1;
    end
  end

  assign capPulse = strobes.timeoutHit ? periodCnt : pulseCnt;
  assign remShift = {rem, 1'b0};
  assign fits     = remShift >= {1'b0, heldPeriod};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldPulse   <= '0;
      heldPeriod  <= '0;
      heldTimeout <= 1'b0;
      satFlag     <= 1'b0;
      rem         <= '0;
      quot        <= '0;
    end else if (strobes.capture) begin
      heldPulse   <= capPulse;
      heldPeriod  <= periodCnt;
      heldTimeout <= strobes.timeoutHit;
      satFlag     <= capPulse >= periodCnt;
      rem         <= capPulse;
      quot        <= '0;
    end else if (strobes.divStep) begin
      rem  <= fits ? CNT_W'(remShift - {1'b0, heldPeriod}) : rem << 1;
      quot <= {quot[PHASE_W-2:0], fits};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid       <= 1'b0;
      phaseCode   <= '0;
      pulseCount  <= '0;
      periodCount <= '0;
      timeout     <= 1'b0;
    end else begin
      valid <= strobes.divDone;
      if (strobes.divDone) begin
        phaseCode   <= satFlag ? '1 : quot;
        pulseCount  <= heldPulse;
        periodCount <= heldPeriod;
        timeout     <= heldTimeout;
      end
    end
  end

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);

  a_r3_pulse_within_period: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> pulseCount <= periodCount);

  a_r5_timeout_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (valid && timeout) |-> (phaseCode == '1 && pulseCount == periodCount));

  a_r7_zero_code: assert property (@(posedge clk) disable iff (!rstN)
    (valid && pulseCount == '0 && periodCount != '0) |-> phaseCode == '0);

endmodule

// File: rtl/pm_phase_meter.sv
module pm_phase_meter
  import pm_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refIn,
  input  logic               rspIn,
  input  logic               sampleEn,
  output logic               valid,
  output logic [PHASE_W-1:0] phaseCode,
  output logic [CNT_W-1:0]   pulseCount,
  output logic [CNT_W-1:0]   periodCount,
  output logic               timeout
);

  pmStrobeT strobes;

  pm_ctrl #(.PHASE_W(PHASE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .refIn(refIn), .rspIn(rspIn),
    .sampleEn(sampleEn), .strobes(strobes)
  );

  pm_datapath #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .valid(valid),
    .phaseCode(phaseCode), .pulseCount(pulseCount),
    .periodCount(periodCount), .timeout(timeout)
  );

endmodule

// File: tb/tb_pm_phase_meter.sv
module tb_pm_phase_meter;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE_W = 8;
  localparam int CNT_W   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic rspIn = 1'b0;
  logic sampleEn = 1'b0;
  logic valid;
  logic [PHASE_W-1:0] phaseCode;
  logic [CNT_W-1:0] pulseCount;
  logic [CNT_W-1:0] periodCount;
  logic timeout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int gP = 16;
  int gL = 0;
  int gK = 1;
  bit gRspOn = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_phase_meter #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .rspIn(rspIn),
    .sampleEn(sampleEn), .valid(valid), .phaseCode(phaseCode),
    .pulseCount(pulseCount), .periodCount(periodCount), .timeout(timeout)
  );

  always @(negedge clk) begin
    refIn    <= (cyc % gP) < (gP / 2);
    rspIn    <= gRspOn && (((cyc + gP - gL) % gP) < (gP / 2));
    sampleEn <= (cyc % gK) == 0;
    cyc      <= cyc + 1;
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s P=%0d L=%0d k=%0d actual=%0d expected=%0d",
               tag, gP, gL, gK, act, exp);
    end
  endtask

  task automatic runCfg(int p, int l, int k, bit rspOn);
    int nValid;
    longint ePer;
    longint ePul;
    longint eCode;
    gP = p; gL = l; gK = k; gRspOn = rspOn;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    cyc = 0;
    rstN = 1'b1;
    ePer = p / k;
    ePul = rspOn ? l / k : ePer;
    eCode = (ePul >= ePer) ? (1 << PHASE_W) - 1 : (ePul << PHASE_W) / ePer;
    nValid = 0;
    while (nValid < 3) begin
      @(negedge clk);
      if (valid) begin
        nValid++;
        if (nValid == 1) begin
          chk("R6 first period full", periodCount, ePer);
        end else begin
          chk(k == 1 ? "R3 period" : "R9 period", periodCount, ePer);
          chk(!rspOn ? "R5 pulse" : (l == 0 ? "R7 pulse" : "R2 pulse"),
              pulseCount, ePul);
          chk(!rspOn ? "R5 code" : (l == 0 ? "R7 code" : "R4 code"),
              phaseCode, eCode);
          chk("R5 timeout flag", timeout, !rspOn);
        end
        @(negedge clk);
        chk("R6 single cycle", valid, 0);
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R8 valid", valid, 0);
    chk("R8 code", phaseCode, 0);
    chk("R8 pulse", pulseCount, 0);
    chk("R8 period", periodCount, 0);
    chk("R8 timeout", timeout, 0);
    // R1 R2 R4 R7: every lag, one sample per cycle
    for (int l = 0; l < 16; l++) runCfg(16, l, 1, 1'b1);
    for (int l = 0; l < 32; l++) runCfg(32, l, 1, 1'b1);
    // R9: sparse enable
    for (int l = 0; l < 48; l += 4) runCfg(48, l, 4, 1'b1);
    for (int l = 0; l < 64; l += 2) runCfg(64, l, 2, 1'b1);
    // R5: response never rises
    runCfg(16, 0, 1, 1'b0);
    runCfg(32, 0, 4, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule